// File: doc/BRIEF.md
# Flash Command Unlock Sequence Decoder

This block sits on the write side of a 16-bit flash command port and turns sequences of bus writes into operation requests. Before any operation is accepted it requires a five-write unlock preamble. Two fixed key bytes frame a block number, which is written twice and must match. A sixth write carries an opcode that picks one of eight operations. A seventh write carries that operation's operand: an address, data, or both.

Seven of the operations are dispatched right after the seventh write. A page program instead continues with a strictly ordered load of 128 words into one page. Each accepted word is reported as it arrives, and the operation is dispatched after the last word. Any break in the sequence raises a one-cycle error pulse and returns the decoder to idle. The array, its timing and status polling belong to other blocks. The downstream controller acts on the start pulse, the operation code and the latched block, address and data.

Top module: `fcmd_unlock_decoder`

## Requirements
- R1: While reset is active and after its release, op_start, seq_err and page_wr_valid are 0, and op_code, op_block, op_addr, op_data and page_wr_offset are all zero.
- R2: A sequence starts only with a write of low byte 60h in idle. It must continue with the block write, then ACh, then the block write again, then 78h. Any other write seen in idle is ignored, with no error.
- R3: Data bits 15 to 8 are ignored in every command write, so any upper byte gives the same result.
- R4: The sequence aborts with seq_err high for exactly one clock, no op_start, and a return to idle, on any of these faults: a wrong key byte, data bit 7 set in a block write, a block number in the second block write that differs from the first, an unknown opcode, a write whose bank (address bits 21:20) differs from the bank of the first write, or a page word whose offset or upper address is out of order.
- R5: Opcode bytes map to op_code as follows: 40h→0 word program, 41h→1 page program, 0Eh→2 buffer to array, 20h→3 block erase, A7h→4 erase all unlocked, 55h→5 clear buffer, 74h→6 single load to buffer, F1h→7 array to buffer.
- R6: For every operation except page program, op_start is high for one clock after the seventh write. op_addr then holds that write's address, op_data its full 16-bit data, and op_block the block number from data bits 6:0 of the block writes.
- R7: For page program, the seventh write is word 0 and 127 more words follow. Address bits 6:0 must count 00h to 7Fh, and bits 21:7 must equal those of word 0. Each accepted word gives a one-clock page_wr_valid with page_wr_offset and op_data set to that word. op_start comes together with the 128th word, and op_addr then holds the page base address.
- R8: For block erase, op_addr keeps bits 21:12 when the bank is 0 and bits 21:15 for any other bank. All lower bits are 0.
- R9: Cycles with wr_en low between the writes of a sequence change nothing and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe, one write per clock while high |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Write data |
| op_start | output | 1 | One-clock operation dispatch pulse |
| op_code | output | 3 | Selected operation |
| op_block | output | 7 | Block number from the preamble |
| op_addr | output | 22 | Latched operand or page base address |
| op_data | output | 16 | Latched operand or current page word data |
| page_wr_valid | output | 1 | One-clock pulse per accepted page word |
| page_wr_offset | output | 7 | Offset of the accepted page word |
| seq_err | output | 1 | One-clock pulse when a sequence aborts |

## Verification
Random sequences pick one of the eight operations, a bank, a block, random operands and a random upper data byte. Each sequence is either clean or carries one fault at a known position. Clean sequences tell apart the opcode mapping and the per-operation operand latching, including the erase masking for each bank. Faulted sequences show that each abort is raised on exactly the offending write and that the decoder restarts cleanly from idle. Directed cases cover stray writes in idle, an all-ones upper byte, idle gaps between writes, a page load broken midway, and a reset taken in the middle of a sequence.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [2:0] {
    OP_WORD_PROG    = 3'd0,
    OP_PAGE_PROG    = 3'd1,
    OP_BUF_TO_ARRAY = 3'd2,
    OP_BLOCK_ERASE  = 3'd3,
    OP_ERASE_ALL    = 3'd4,
    OP_BUF_CLEAR    = 3'd5,
    OP_BUF_LOAD     = 3'd6,
    OP_ARRAY_TO_BUF = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_BLK_A, S_KEY_B, S_BLK_B, S_KEY_C, S_OPC, S_OPND, S_PAGE
  } st_e;

  localparam logic [7:0] KEY_A = 8'h60;
  localparam logic [7:0] KEY_B = 8'hAC;
  localparam logic [7:0] KEY_C = 8'h78;
endpackage

// File: rtl/fcmd_opc_map.sv
module fcmd_opc_map
  import fcmd_pkg::*;
(
  input  logic [7:0] opc_byte,
  output logic       opc_valid,
  output op_e        opc_op
);
  always_comb begin
    opc_valid = 1'b1;
    opc_op    = OP_WORD_PROG;
    unique case (opc_byte)
      8'h40:   opc_op = OP_WORD_PROG;
      8'h41:   opc_op = OP_PAGE_PROG;
      8'h0E:   opc_op = OP_BUF_TO_ARRAY;
      8'h20:   opc_op = OP_BLOCK_ERASE;
      8'hA7:   opc_op = OP_ERASE_ALL;
      8'h55:   opc_op = OP_BUF_CLEAR;
      8'h74:   opc_op = OP_BUF_LOAD;
      8'hF1:   opc_op = OP_ARRAY_TO_BUF;
      default: opc_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmd_page_track.sv
module fcmd_page_track #(
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [OFF_W-1:0] expect_off,
  output logic             last_word
);
  logic [OFF_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | adv;
    cnt_n  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign expect_off = cnt_q;
  assign last_word  = &cnt_q;

  // R7: clearing and advancing never happen on the same write
  a_r7_no_clr_adv: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && adv));
endmodule

// File: rtl/fcmd_unlock_decoder.sv
module fcmd_unlock_decoder
  import fcmd_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 2,
  parameter int BLK_W     = 7,
  parameter int OFF_W     = 7,
  parameter int ERASE_LSB_BANK0 = 12,
  parameter int ERASE_LSB_OTHER = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              op_start,
  output logic [2:0]        op_code,
  output logic [BLK_W-1:0]  op_block,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              page_wr_valid,
  output logic [OFF_W-1:0]  page_wr_offset,
  output logic              seq_err
);
  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MASK_BANK0 = ONES << ERASE_LSB_BANK0;
  localparam logic [ADDR_W-1:0] MASK_OTHER = ONES << ERASE_LSB_OTHER;

  st_e               st_q, st_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [BLK_W-1:0]  blk_q, blk_n;
  op_e               op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [OFF_W-1:0]  off_q, off_n;
  logic              start_n, err_n, pw_n;
  logic              start_q, err_q, pw_q;

  logic [BANK_W-1:0] bank_in;
  logic [7:0]        lo;
  logic              bank_ok, blk_ok;
  logic              opc_valid;
  op_e               opc_op;
  logic              trk_clr, trk_adv, trk_last;
  logic [OFF_W-1:0]  trk_exp;
  logic [ADDR_W-1:0] erase_mask;

  assign bank_in    = wr_addr[ADDR_W-1 -: BANK_W];
  assign lo         = wr_data[7:0];
  assign bank_ok    = (bank_in == bank_q);
  assign blk_ok     = ~lo[7];
  assign erase_mask = (bank_in == '0) ? MASK_BANK0 : MASK_OTHER;

  fcmd_opc_map u_opc_map (
    .opc_byte (lo),
    .opc_valid(opc_valid),
    .opc_op   (opc_op)
  );

  fcmd_page_track #(.OFF_W(OFF_W)) u_page_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (trk_clr),
    .adv       (trk_adv),
    .expect_off(trk_exp),
    .last_word (trk_last)
  );

  always_comb begin
    st_n = st_q;   bank_n = bank_q; blk_n = blk_q;  op_n = op_q;
    addr_n = addr_q; data_n = data_q; off_n = off_q;
    start_n = 1'b0; err_n = 1'b0; pw_n = 1'b0;
    trk_clr = 1'b0; trk_adv = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        S_IDLE: if (lo == KEY_A) begin
          bank_n = bank_in;
          st_n   = S_BLK_A;
        end
        S_BLK_A: if (bank_ok && blk_ok) begin
          blk_n = lo[BLK_W-1:0];
          st_n  = S_KEY_B;
        end else err_n = 1'b1;
        S_KEY_B: if (bank_ok && lo == KEY_B) st_n = S_BLK_B;
                 else err_n = 1'b1;
        S_BLK_B: if (bank_ok && blk_ok && lo[BLK_W-1:0] == blk_q) st_n = S_KEY_C;
                 else err_n = 1'b1;
        S_KEY_C: if (bank_ok && lo == KEY_C) st_n = S_OPC;
                 else err_n = 1'b1;
        S_OPC: if (bank_ok && opc_valid) begin
          op_n    = opc_op;
          trk_clr = 1'b1;
          st_n    = S_OPND;
        end else err_n = 1'b1;
        S_OPND: begin
          if (!bank_ok) err_n = 1'b1;
          else if (op_q == OP_PAGE_PROG) begin
            if (wr_addr[OFF_W-1:0] == trk_exp) begin
              addr_n  = wr_addr;
              data_n  = wr_data;
              off_n   = trk_exp;
              pw_n    = 1'b1;
              trk_adv = 1'b1;
              st_n    = S_PAGE;
            end else err_n = 1'b1;
          end else begin
            addr_n  = (op_q == OP_BLOCK_ERASE) ? (wr_addr & erase_mask) : wr_addr;
            data_n  = wr_data;
            start_n = 1'b1;
            st_n    = S_IDLE;
          end
        end
        S_PAGE: if (wr_addr[ADDR_W-1:OFF_W] == addr_q[ADDR_W-1:OFF_W] &&
                    wr_addr[OFF_W-1:0] == trk_exp) begin
          data_n  = wr_data;
          off_n   = trk_exp;
          pw_n    = 1'b1;
          trk_adv = 1'b1;
          if (trk_last) begin
            start_n = 1'b1;
            st_n    = S_IDLE;
          end
        end else err_n = 1'b1;
        default: st_n = S_IDLE;
      endcase
      if (err_n) st_n = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bank_q <= '0; blk_q <= '0; op_q <= OP_WORD_PROG;
      addr_q <= '0; data_q <= '0; off_q <= '0;
      start_q <= 1'b0; err_q <= 1'b0; pw_q <= 1'b0;
    end else begin
      if (wr_en) begin
        st_q <= st_n; bank_q <= bank_n; blk_q <= blk_n; op_q <= op_n;
        addr_q <= addr_n; data_q <= data_n; off_q <= off_n;
      end
      start_q <= start_n;
      err_q   <= err_n;
      pw_q    <= pw_n;
    end
  end

  assign op_start       = start_q;
  assign seq_err        = err_q;
  assign page_wr_valid  = pw_q;
  assign page_wr_offset = off_q;
  assign op_code        = op_q;
  assign op_block       = blk_q;
  assign op_addr        = addr_q;
  assign op_data        = data_q;

  // R6: dispatch lasts one clock
  a_r6_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  // R4: an abort never dispatches
  a_r4_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !op_start);
  // R4: an abort pulse lasts one clock
  a_r4_err_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);
  // R7: page dispatch coincides with the final word
  a_r7_page_end: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_code == OP_PAGE_PROG) |-> (page_wr_valid && &page_wr_offset));
  // R8: erase address has no bits below the block field
  a_r8_erase_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_code == OP_BLOCK_ERASE) |-> (op_addr[ERASE_LSB_BANK0-1:0] == '0));
endmodule

// File: tb/tb_fcmd_unlock_decoder.sv
module tb_fcmd_unlock_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [21:0] wr_addr;
  logic [15:0] wr_data;
  logic        op_start, page_wr_valid, seq_err;
  logic [2:0]  op_code;
  logic [6:0]  op_block, page_wr_offset;
  logic [21:0] op_addr;
  logic [15:0] op_data;

  int checks = 0;
  int errors = 0;
  int gap_max = 0;
  bit force_ff = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmd_unlock_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_start(op_start), .op_code(op_code), .op_block(op_block), .op_addr(op_addr),
    .op_data(op_data), .page_wr_valid(page_wr_valid), .page_wr_offset(page_wr_offset),
    .seq_err(seq_err)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] opc_byte(int i);
    case (i)
      0: return 8'h40; 1: return 8'h41; 2: return 8'h0E; 3: return 8'h20;
      4: return 8'hA7; 5: return 8'h55; 6: return 8'h74; default: return 8'hF1;
    endcase
  endfunction

  function automatic logic [21:0] exp_addr(int op, logic [21:0] a);
    if (op != 3) return a;
    if (a[21:20] == 2'd0) return {a[21:12], 12'd0};
    return {a[21:15], 15'd0};
  endfunction

  function automatic logic [7:0] upper();
    return force_ff ? 8'hFF : 8'($urandom);
  endfunction

  task automatic idle_gap();
    int n = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
    repeat (n) begin
      @(posedge clk); #1;
      chk(!op_start && !seq_err && !page_wr_valid, "R9", "pulse during gap",
          {op_start, seq_err, page_wr_valid}, 0);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [15:0] d);
    idle_gap();
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr_chk(logic [21:0] a, logic [15:0] d, bit e_err, bit e_start, string req);
    wr(a, d);
    chk(seq_err == e_err, req, "seq_err", seq_err, e_err);
    chk(op_start == e_start, req, "op_start", op_start, e_start);
  endtask

  function automatic logic [21:0] baddr(logic [1:0] b);
    return {b, 20'($urandom)};
  endfunction

  // fault: 0 none, 1 bad key B, 2 bit7 in block, 3 block differs, 4 bad opcode,
  // 5 bank change, 6 page offset out of order, 7 bad key C
  task automatic run_seq(int op, int fault, logic [1:0] bk, logic [6:0] blk);
    logic [21:0] a;
    logic [15:0] d;
    logic [21:0] base;
    int bad_w;
    wr_chk(baddr(bk), {upper(), 8'h60}, 0, 0, "R2");
    wr_chk(baddr(bk), {upper(), (fault == 2), blk}, fault == 2, 0, fault == 2 ? "R4" : "R2");
    if (fault == 2) return;
    wr_chk(baddr(bk), {upper(), (fault == 1) ? 8'hAD : 8'hAC}, fault == 1, 0,
           fault == 1 ? "R4" : "R2");
    if (fault == 1) return;
    wr_chk(baddr(bk), {upper(), 1'b0, (fault == 3) ? blk ^ 7'h1 : blk}, fault == 3, 0,
           fault == 3 ? "R4" : "R2");
    if (fault == 3) return;
    wr_chk(baddr((fault == 5) ? bk ^ 2'd1 : bk), {upper(), (fault == 7) ? 8'h79 : 8'h78},
           fault == 5 || fault == 7, 0, (fault == 5 || fault == 7) ? "R4" : "R2");
    if (fault == 5 || fault == 7) return;
    wr_chk(baddr(bk), {upper(), (fault == 4) ? 8'h00 : opc_byte(op)}, fault == 4, 0,
           fault == 4 ? "R4" : "R5");
    if (fault == 4) return;
    if (op != 1) begin
      a = baddr(bk); d = 16'($urandom);
      wr_chk(a, d, 0, 1, "R6");
      chk(op_code == 3'(op), "R5", "op_code", op_code, op);
      chk(op_addr == exp_addr(op, a), op == 3 ? "R8" : "R6", "op_addr", op_addr, exp_addr(op, a));
      chk(op_data == d, "R6", "op_data", op_data, d);
      chk(op_block == blk, "R6", "op_block", op_block, blk);
    end else begin
      base = {bk, 13'($urandom), 7'd0};
      bad_w = (fault == 6) ? int'($urandom % 127) + 1 : 999;
      for (int w = 0; w < 128; w++) begin
        a = base | 22'((w == bad_w) ? w + 1 : w);
        d = 16'($urandom);
        wr_chk(a, d, w == bad_w, w == 127, w == bad_w ? "R4" : "R7");
        if (w == bad_w) begin
          chk(!page_wr_valid, "R4", "page_wr_valid on bad word", page_wr_valid, 0);
          return;
        end
        chk(page_wr_valid && page_wr_offset == 7'(w), "R7", "page word offset",
            {page_wr_valid, page_wr_offset}, {1'b1, 7'(w)});
        chk(op_data == d, "R7", "page word data", op_data, d);
      end
      chk(op_code == 3'd1 && op_addr == base, "R7", "page dispatch addr", op_addr, base);
      chk(op_block == blk, "R7", "page op_block", op_block, blk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int op, fault;
    void'($urandom(32'd1234));
    wr_en = 0; wr_addr = '0; wr_data = '0; rst_n = 0;
    repeat (3) @(posedge clk); #1;
    chk(!op_start && !seq_err && !page_wr_valid && op_addr == 0 && op_data == 0 &&
        op_code == 0 && op_block == 0 && page_wr_offset == 0, "R1", "reset state", op_addr, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2: stray writes in idle are ignored
    wr_chk(22'h100000, 16'h0040, 0, 0, "R2");
    wr_chk(22'h000000, 16'h00AC, 0, 0, "R2");
    // R3: all-ones upper byte
    force_ff = 1;
    run_seq(0, 0, 2'd1, 7'h2A);
    force_ff = 0;
    // R8: erase masks for bank 0 and a non-zero bank
    run_seq(3, 0, 2'd0, 7'h05);
    run_seq(3, 0, 2'd2, 7'h7F);
    // R9: gaps between writes
    gap_max = 3;
    run_seq(6, 0, 2'd3, 7'h11);
    run_seq(1, 0, 2'd1, 7'h33);
    gap_max = 0;
    // R4: page broken midway, then a clean page
    run_seq(1, 6, 2'd2, 7'h01);
    run_seq(1, 0, 2'd0, 7'h40);

    for (int it = 0; it < 60; it++) begin
      op = int'($urandom % 8);
      fault = int'($urandom % 8);
      if (fault == 6 && op != 1) fault = 0;
      gap_max = (it % 4 == 0) ? 2 : 0;
      run_seq(op, fault, 2'($urandom), 7'($urandom));
    end
    gap_max = 0;

    // R1: reset in the middle of a sequence
    wr_chk(22'h200000, 16'h0060, 0, 0, "R2");
    wr_chk(22'h200000, 16'h0011, 0, 0, "R2");
    rst_n = 0; #1;
    chk(op_addr == 0 && op_block == 0 && op_data == 0 && op_code == 0, "R1",
        "mid-sequence reset", op_block, 0);
    @(posedge clk); #1; rst_n = 1;
    wr_chk(22'h200000, 16'h00AC, 0, 0, "R1");
    run_seq(7, 0, 2'd2, 7'h22);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule